// File: doc/BRIEF.md
# Status-Flag Branch Condition Unit

This unit sits beside the program counter of an 8-bit microcontroller core. Each cycle it may be handed an already-decoded control-flow class, together with:

- the 8-bit status register;
- a flag-select index;
- a 7-bit signed relative displacement;
- the current program counter;
- the outcome of a compare-equal or bit test for skip instructions;
- a hint saying whether the instruction after the current one is two words long.

From these it decides whether control flow leaves the straight-line path. It produces the next program counter and the number of cycles the instruction occupies.

Single-flag branches address any status bit by index, in either polarity. The unsigned aliases need no class of their own:

- unsigned lower is carry set;
- unsigned same-or-higher is carry clear;
- equal and not-equal test the zero bit;
- minus and plus test the negative bit.

Signed ordering gets its own classes, which test the exclusive OR of the negative and overflow bits. Strict greater-than and less-or-equal are obtained by the software swapping the operands of the preceding compare and using the opposite test.

The result is registered. It appears one clock after the request, which suits a pipeline that redirects fetch on the following edge.

Top module: `brcond_unit`

## Requirements
- R1: While `rst` is high, on each clock edge `out_valid`, `redirect`, `next_pc` and `cycles` are all driven to zero.
- R2: Class 1 (branch-if-set) redirects exactly when `status[flag_idx]` is 1. Class 2 (branch-if-clear) redirects exactly when that bit is 0. The status bit order from bit 7 down to bit 0 is I, T, H, S, V, N, Z, C, so carry is index 0, zero is index 1, half-carry is index 5, T is index 6 and the interrupt flag is index 7.
- R3: A taken branch of classes 1 to 4 gives `next_pc` = `pc` + 1 + sign-extended `offset`, modulo 2^PC_W, with `cycles` = 2. A branch that is not taken gives `pc` + 1 with `cycles` = 1.
- R4: Class 3 (signed greater-or-equal) redirects when status bit 2 (N) XOR status bit 3 (V) is 0. Class 4 (signed less-than) redirects when that XOR is 1. N alone never decides the outcome.
- R5: For class 5 (skip) with `skip_hit` = 1, `redirect` = 1 and `next_pc` = `pc` + 2 with `cycles` = 2, or `pc` + 3 with `cycles` = 3 when `next_is_two_word` = 1. With `skip_hit` = 0 the result is `pc` + 1, `cycles` = 1, `redirect` = 0, and `offset` plays no part.
- R6: Class 0 (sequential) and the unused codes 6 and 7 give `pc` + 1, `cycles` = 1 and `redirect` = 0, whatever `status`, `offset`, `skip_hit` and `next_is_two_word` hold.
- R7: Outputs are registered. One clock after `in_valid` is high, `out_valid` is 1 and the other outputs carry the result. One clock after `in_valid` is low, `out_valid` is 0 and `redirect`, `next_pc` and `cycles` keep their previous values.
- R8: `next_is_two_word` and `skip_hit` have no effect on branch classes 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A control-flow request is present this cycle |
| op_class | input | 3 | 0 sequential, 1 branch-if-set, 2 branch-if-clear, 3 signed greater-or-equal, 4 signed less-than, 5 skip |
| status | input | SR_W (8) | Status register, I T H S V N Z C from bit 7 down |
| flag_idx | input | $clog2(SR_W) (3) | Status bit tested by classes 1 and 2 |
| offset | input | OFS_W (7) | Two's-complement relative displacement |
| pc | input | PC_W (16) | Address of the current instruction |
| skip_hit | input | 1 | Compare-equal or bit test result for a skip |
| next_is_two_word | input | 1 | The following instruction occupies two words |
| out_valid | output | 1 | Registered result is valid |
| redirect | output | 1 | Flow leaves the straight-line path |
| next_pc | output | PC_W (16) | Next program counter |
| cycles | output | 2 | Cycles the instruction takes (1, 2 or 3) |

## Verification
The single-flag classes are tried on several bit positions in both polarities, with the tested bit alone set or alone cleared against its neighbours. This separates a correct index decode from an off-by-one or an inverted polarity.

The signed classes are driven with all four combinations of N and V. The cases where V alone is set show that a design testing N alone is wrong.

Displacements of +63, -64, -1 and 0, applied at PC 0 and at the top of the address space, expose missing sign extension and wrong wrap-around. Skips with and without a two-word successor, and with a miss, separate the three skip lengths.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

  localparam int CYC_W = 2;

  // status bit positions the signed classes rely on
  localparam int SR_NEG_BIT = 2;
  localparam int SR_OVF_BIT = 3;

  typedef enum logic [2:0] {
    BC_SEQ    = 3'd0,
    BC_IF_SET = 3'd1,
    BC_IF_CLR = 3'd2,
    BC_SGE    = 3'd3,
    BC_SLT    = 3'd4,
    BC_SKIP   = 3'd5
  } bc_op_e;

endpackage

// File: rtl/brcond_eval.sv
module brcond_eval
  import brcond_pkg::*;
#(
  parameter int SR_W = 8,
  localparam int IDX_W = $clog2(SR_W)
) (
  input  logic [2:0]       op_class,
  input  logic [SR_W-1:0]  status,
  input  logic [IDX_W-1:0] flag_idx,
  input  logic             skip_hit,
  output logic             take
);

  logic sel_bit;
  logic signed_lt;

  assign sel_bit   = status[flag_idx];
  assign signed_lt = status[SR_NEG_BIT] ^ status[SR_OVF_BIT];

  always_comb begin
    case (op_class)
      BC_IF_SET: take = sel_bit;
      BC_IF_CLR: take = ~sel_bit;
      BC_SGE:    take = ~signed_lt;
      BC_SLT:    take = signed_lt;
      BC_SKIP:   take = skip_hit;
      default:   take = 1'b0;
    endcase
  end

endmodule

// File: rtl/brcond_target.sv
module brcond_target
  import brcond_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFS_W = 7
) (
  input  logic [2:0]       op_class,
  input  logic             take,
  input  logic [PC_W-1:0]  pc,
  input  logic [OFS_W-1:0] offset,
  input  logic             next_is_two_word,
  output logic [PC_W-1:0]  next_pc,
  output logic [CYC_W-1:0] cycles
);

  localparam logic [PC_W-1:0] PC_ONE   = PC_W'(1);
  localparam logic [PC_W-1:0] PC_TWO   = PC_W'(2);
  localparam logic [PC_W-1:0] PC_THREE = PC_W'(3);

  logic [PC_W-1:0] ofs_ext;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] branch_pc;
  logic [PC_W-1:0] skip_pc;
  logic            is_branch;

  generate
    if (OFS_W < PC_W) begin : g_sext
      assign ofs_ext = {{(PC_W-OFS_W){offset[OFS_W-1]}}, offset};
    end else begin : g_trunc
      assign ofs_ext = offset[PC_W-1:0];
    end
  endgenerate

  // both candidates computed in parallel; take only steers the mux
  assign seq_pc    = pc + PC_ONE;
  assign branch_pc = seq_pc + ofs_ext;
  assign skip_pc   = pc + (next_is_two_word ? PC_THREE : PC_TWO);

  assign is_branch = (op_class == BC_IF_SET) || (op_class == BC_IF_CLR) ||
                     (op_class == BC_SGE)    || (op_class == BC_SLT);

  always_comb begin
    next_pc = seq_pc;
    cycles  = CYC_W'(1);
    if (take) begin
      if (is_branch) begin
        next_pc = branch_pc;
        cycles  = CYC_W'(2);
      end else if (op_class == BC_SKIP) begin
        next_pc = skip_pc;
        cycles  = next_is_two_word ? CYC_W'(3) : CYC_W'(2);
      end
    end
  end

endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
  import brcond_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFS_W = 7,
  parameter int SR_W  = 8,
  localparam int IDX_W = $clog2(SR_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       op_class,
  input  logic [SR_W-1:0]  status,
  input  logic [IDX_W-1:0] flag_idx,
  input  logic [OFS_W-1:0] offset,
  input  logic [PC_W-1:0]  pc,
  input  logic             skip_hit,
  input  logic             next_is_two_word,
  output logic             out_valid,
  output logic             redirect,
  output logic [PC_W-1:0]  next_pc,
  output logic [1:0]       cycles
);

  logic             take_c;
  logic [PC_W-1:0]  npc_c;
  logic [CYC_W-1:0] cyc_c;

  brcond_eval #(.SR_W(SR_W)) u_eval (
    .op_class (op_class),
    .status   (status),
    .flag_idx (flag_idx),
    .skip_hit (skip_hit),
    .take     (take_c)
  );

  brcond_target #(.PC_W(PC_W), .OFS_W(OFS_W)) u_target (
    .op_class         (op_class),
    .take             (take_c),
    .pc               (pc),
    .offset           (offset),
    .next_is_two_word (next_is_two_word),
    .next_pc          (npc_c),
    .cycles           (cyc_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      redirect  <= 1'b0;
      next_pc   <= '0;
      cycles    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        redirect <= take_c;
        next_pc  <= npc_c;
        cycles   <= cyc_c;
      end
    end
  end

endmodule

// File: rtl/brcond_chk.sv
module brcond_chk
  import brcond_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int SR_W = 8,
  localparam int IDX_W = $clog2(SR_W)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [2:0]       op_class,
  input logic [SR_W-1:0]  status,
  input logic [IDX_W-1:0] flag_idx,
  input logic [PC_W-1:0]  pc,
  input logic             skip_hit,
  input logic             out_valid,
  input logic             redirect,
  input logic [PC_W-1:0]  next_pc,
  input logic [1:0]       cycles
);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && !redirect && next_pc == '0 && cycles == 2'd0));

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(next_pc) && $stable(cycles) && $stable(redirect)));

  a_r3_cycle_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (redirect ? (cycles == 2'd2 || cycles == 2'd3) : cycles == 2'd1));

  a_r2_set_bit: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_class == 3'd1) |=> (redirect == $past(status[flag_idx])));

  a_r4_signed_ge: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_class == 3'd3) |=>
      (redirect != $past(status[SR_NEG_BIT] ^ status[SR_OVF_BIT])));

  a_r5_skip_miss: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_class == 3'd5 && !skip_hit) |=>
      (!redirect && next_pc == $past(pc) + 1'b1 && cycles == 2'd1));

  a_r6_sequential: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_class == 3'd0) |=> (!redirect && cycles == 2'd1));

endmodule

bind brcond_unit brcond_chk #(.PC_W(PC_W), .SR_W(SR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_class  (op_class),
  .status    (status),
  .flag_idx  (flag_idx),
  .pc        (pc),
  .skip_hit  (skip_hit),
  .out_valid (out_valid),
  .redirect  (redirect),
  .next_pc   (next_pc),
  .cycles    (cycles)
);

// File: tb/sim_brcond_unit.sv
`timescale 1ns/1ps
module sim_brcond_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op_class = '0;
  logic [7:0]  status = '0;
  logic [2:0]  flag_idx = '0;
  logic [6:0]  offset = '0;
  logic [15:0] pc = '0;
  logic        skip_hit = 1'b0;
  logic        next_is_two_word = 1'b0;
  logic        out_valid;
  logic        redirect;
  logic [15:0] next_pc;
  logic [1:0]  cycles;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  brcond_unit u0 (
    .clk (clk), .rst (rst), .in_valid (in_valid), .op_class (op_class),
    .status (status), .flag_idx (flag_idx), .offset (offset), .pc (pc),
    .skip_hit (skip_hit), .next_is_two_word (next_is_two_word),
    .out_valid (out_valid), .redirect (redirect), .next_pc (next_pc),
    .cycles (cycles)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  sr;
    logic [2:0]  idx;
    logic [6:0]  ofs;
    logic [15:0] pc;
    logic        skip;
    logic        two;
    logic        redir;
    logic [15:0] npc;
    logic [1:0]  cyc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    // R2: carry (index 0) set / clear
    '{3'd1, 8'h01, 3'd0, 7'h05, 16'h0100, 1'b0, 1'b0, 1'b1, 16'h0106, 2'd2, 4'd2},
    '{3'd1, 8'hFE, 3'd0, 7'h05, 16'h0100, 1'b0, 1'b0, 1'b0, 16'h0101, 2'd1, 4'd2},
    // R3: displacement -1, -64, +63
    '{3'd2, 8'hFE, 3'd0, 7'h7F, 16'h0200, 1'b0, 1'b0, 1'b1, 16'h0200, 2'd2, 4'd3},
    '{3'd1, 8'h80, 3'd7, 7'h40, 16'h1000, 1'b0, 1'b0, 1'b1, 16'h0FC1, 2'd2, 4'd3},
    '{3'd1, 8'h02, 3'd1, 7'h3F, 16'h0010, 1'b0, 1'b0, 1'b1, 16'h0050, 2'd2, 4'd3},
    // R2: zero clear-test with Z set
    '{3'd2, 8'h02, 3'd1, 7'h3F, 16'h0010, 1'b0, 1'b0, 1'b0, 16'h0011, 2'd1, 4'd2},
    // R4: N^V combinations
    '{3'd3, 8'h0C, 3'd0, 7'h02, 16'h0300, 1'b0, 1'b0, 1'b1, 16'h0303, 2'd2, 4'd4},
    '{3'd3, 8'h04, 3'd0, 7'h02, 16'h0300, 1'b0, 1'b0, 1'b0, 16'h0301, 2'd1, 4'd4},
    '{3'd4, 8'h04, 3'd0, 7'h7E, 16'h0300, 1'b0, 1'b0, 1'b1, 16'h02FF, 2'd2, 4'd4},
    '{3'd4, 8'h08, 3'd0, 7'h00, 16'h0400, 1'b0, 1'b0, 1'b1, 16'h0401, 2'd2, 4'd4},
    '{3'd4, 8'h00, 3'd0, 7'h00, 16'h0400, 1'b0, 1'b0, 1'b0, 16'h0401, 2'd1, 4'd4},
    '{3'd3, 8'h08, 3'd0, 7'h00, 16'h0500, 1'b0, 1'b0, 1'b0, 16'h0501, 2'd1, 4'd4},
    '{3'd4, 8'hF3, 3'd0, 7'h10, 16'h0500, 1'b0, 1'b0, 1'b0, 16'h0501, 2'd1, 4'd4},
    // R5: skip lengths and miss
    '{3'd5, 8'h00, 3'd0, 7'h10, 16'h0600, 1'b1, 1'b0, 1'b1, 16'h0602, 2'd2, 4'd5},
    '{3'd5, 8'h00, 3'd0, 7'h10, 16'h0600, 1'b1, 1'b1, 1'b1, 16'h0603, 2'd3, 4'd5},
    '{3'd5, 8'hFF, 3'd0, 7'h10, 16'h0600, 1'b0, 1'b1, 1'b0, 16'h0601, 2'd1, 4'd5},
    // R6: sequential and unused codes
    '{3'd0, 8'hFF, 3'd0, 7'h10, 16'h0700, 1'b1, 1'b1, 1'b0, 16'h0701, 2'd1, 4'd6},
    '{3'd7, 8'hFF, 3'd0, 7'h10, 16'h0700, 1'b1, 1'b1, 1'b0, 16'h0701, 2'd1, 4'd6},
    '{3'd6, 8'hFF, 3'd2, 7'h10, 16'h0700, 1'b1, 1'b0, 1'b0, 16'h0701, 2'd1, 4'd6},
    // R8: skip inputs ignored by a branch (half-carry, index 5)
    '{3'd1, 8'h20, 3'd5, 7'h04, 16'h0800, 1'b1, 1'b1, 1'b1, 16'h0805, 2'd2, 4'd8},
    // R3: wrap at both ends
    '{3'd1, 8'h01, 3'd0, 7'h00, 16'hFFFF, 1'b0, 1'b0, 1'b1, 16'h0000, 2'd2, 4'd3},
    '{3'd2, 8'h00, 3'd0, 7'h7E, 16'h0000, 1'b0, 1'b0, 1'b1, 16'hFFFF, 2'd2, 4'd3},
    // R2: T bit (index 6) clear among set neighbours
    '{3'd1, 8'hBF, 3'd6, 7'h08, 16'h0900, 1'b0, 1'b0, 1'b0, 16'h0901, 2'd1, 4'd2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    op_class = v.op; status = v.sr; flag_idx = v.idx; offset = v.ofs;
    pc = v.pc; skip_hit = v.skip; next_is_two_word = v.two;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset outputs", {out_valid, redirect, next_pc, cycles}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 idle after reset", {31'd0, out_valid}, 32'd0);

    // table walk, one request per cycle, sampled one clock later
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      chk($sformatf("R%0d vector %0d", VECS[i].req, i),
          {12'd0, out_valid, redirect, next_pc, cycles},
          {12'd0, 1'b1, VECS[i].redir, VECS[i].npc, VECS[i].cyc});
    end

    // R7: idle cycle keeps last result and clears out_valid
    in_valid = 1'b0;
    drive('{3'd1, 8'hFF, 3'd0, 7'h20, 16'h4444, 1'b1, 1'b1, 1'b0, 16'h0, 2'd0, 4'd7});
    @(negedge clk);
    chk("R7 idle hold", {12'd0, out_valid, redirect, next_pc, cycles},
        {12'd0, 1'b0, 1'b0, 16'h0901, 2'd1});

    // R7: back-to-back requests, each visible one clock later
    in_valid = 1'b1;
    drive('{3'd5, 8'h00, 3'd0, 7'h00, 16'h2000, 1'b1, 1'b1, 1'b0, 16'h0, 2'd0, 4'd7});
    @(negedge clk);
    drive('{3'd1, 8'h40, 3'd6, 7'h01, 16'h3000, 1'b0, 1'b0, 1'b0, 16'h0, 2'd0, 4'd7});
    chk("R7 first of pair", {12'd0, out_valid, redirect, next_pc, cycles},
        {12'd0, 1'b1, 1'b1, 16'h2003, 2'd3});
    @(negedge clk);
    chk("R7 second of pair", {12'd0, out_valid, redirect, next_pc, cycles},
        {12'd0, 1'b1, 1'b1, 16'h3002, 2'd2});

    // R1: reset during activity clears everything
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset", {out_valid, redirect, next_pc, cycles}, 32'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule